// File: doc/BRIEF.md
# Event-Start, Clock-Stop Interval Generator

This block converts an asynchronous event edge into a timing pulse. The pulse starts the moment the event arrives and ends on the local clock. An event sets a start flop directly, with no clock alignment. The first local clock edge after the event copies that flop into a hold flop. The next edge uses the hold flop to clear the start flop, which ends the pulse.

The pulse therefore always lasts more than one clock period and no more than two. With a 1 GHz local clock it never exceeds 2 ns. The margin gives the measuring circuit time to recover when an event lands close to a clock edge.

The pulse feeds an external time stretcher or width counter, and it also tells the control side that an event has occurred. Once the pulse has ended, a one-cycle done pulse is raised. The block then ignores further events until the control side rearms it.

Top module: `evt_interval_gen`

## Requirements
- R1: While the block is ready, an active event edge raises `interval_o` at once, with no wait for a clock edge. With `EVT_RISING`=1 the active edge is the rising edge of `evt_i`.
- R2: On the first clock edge after the event, the block disarms and `ready_o` goes low.
- R3: `interval_o` falls on the second clock edge after the event.
- R4: If the event lands o ps after a clock edge, with clock period T and 0 < o < T, the interval lasts 2T - o. That length is greater than T and at most 2T.
- R5: `done_o` goes high for exactly one cycle, starting at the clock edge after the one on which `interval_o` fell.
- R6: While an interval is open, further event edges do not restart or extend it. After the interval, event edges are ignored until the block is rearmed.
- R7: `rearm_i`, sampled on a clock edge while no interval, hold or done state is active, sets `ready_o` high after that edge. While the block is busy, `rearm_i` has no effect.
- R8: While `srst` is high, events cannot start an interval. A clock edge with `srst` high clears `interval_o` and `done_o`. After reset, `ready_o` is high.
- R9: With `EVT_RISING`=0 the active edge is the falling edge of `evt_i`, and R1 through R6 apply to that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local measurement clock |
| srst | input | 1 | Synchronous reset, active high; also blocks events |
| evt_i | input | 1 | Asynchronous event from the discriminator |
| rearm_i | input | 1 | Arms the block for the next event after readout |
| interval_o | output | 1 | Measured interval pulse and event indication |
| done_o | output | 1 | One-cycle pulse after the interval closes |
| ready_o | output | 1 | High when an event would start an interval |

## Verification
The bench builds two instances. One uses `EVT_RISING`=1 and carries every ordering and corner test. The other uses `EVT_RISING`=0 and shows that the falling-edge variant measures the same lengths. The time unit is 1 ps against a 1000 ps clock, so each interval length is compared exactly with 2T - o. Event offsets sit close to both the opening and the closing clock edge, which covers both ends of the one-to-two-period range.

// File: rtl/evt_interval_gen.sv
`timescale 1ps/1ps
module evt_interval_gen #(
  parameter bit EVT_RISING = 1'b1
) (
  input  logic clk,
  input  logic srst,
  input  logic evt_i,
  input  logic rearm_i,
  output logic interval_o,
  output logic done_o,
  output logic ready_o
);
  logic start_q, hold_q, done_q, armed_q;
  logic evt_lvl, fire, idle;

  assign evt_lvl = EVT_RISING ? evt_i : ~evt_i;
  assign fire    = evt_lvl & armed_q & ~start_q & ~srst;
  assign idle    = ~start_q & ~hold_q & ~done_q;

  always_ff @(posedge clk or posedge fire)
    if (fire)                start_q <= 1'b1;
    else if (srst || hold_q) start_q <= 1'b0;

  always_ff @(posedge clk) begin
    if (srst) begin
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      hold_q <= start_q;
      done_q <= hold_q & ~start_q;
      if (start_q)              armed_q <= 1'b0;
      else if (rearm_i && idle) armed_q <= 1'b1;
    end
  end

  assign interval_o = start_q;
  assign done_o     = done_q;
  assign ready_o    = armed_q & ~start_q;

  a_r3_close_after_hold: assert property (@(posedge clk) disable iff (srst)
    $rose(hold_q) |=> !start_q);
  a_r4_max_two_edges: assert property (@(posedge clk) disable iff (srst)
    (start_q && $past(start_q)) |=> !start_q);
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (srst)
    done_q |=> !done_q);
  a_r6_no_start_disarmed: assert property (@(posedge clk) disable iff (srst)
    (!armed_q && !start_q && !rearm_i) |=> !start_q);
  a_r8_reset_clears: assert property (@(posedge clk)
    srst |=> (!hold_q && !done_q));
  a_r8_reset_blocks: assert property (@(posedge clk)
    (srst && $past(srst)) |-> !start_q);
endmodule

// File: tb/tb_evt_interval_gen.sv
`timescale 1ps/1ps
module tb_evt_interval_gen;
  localparam int CLK_PERIOD = 1000;
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{20, 1980}, '{250, 1750}, '{500, 1500},
                                  '{750, 1250}, '{980, 1020}};

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic evt = 1'b0;
  logic evt_f = 1'b1;
  logic rearm = 1'b0;
  logic intv, done, ready, intv_f, done_f, ready_f;
  int errors = 0;
  int checks = 0;
  longint t0, t1;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_interval_gen #(.EVT_RISING(1'b1)) dut (
    .clk(clk), .srst(srst), .evt_i(evt), .rearm_i(rearm),
    .interval_o(intv), .done_o(done), .ready_o(ready));

  evt_interval_gen #(.EVT_RISING(1'b0)) dut_fall (
    .clk(clk), .srst(srst), .evt_i(evt_f), .rearm_i(rearm),
    .interval_o(intv_f), .done_o(done_f), .ready_o(ready_f));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rearm();
    rearm = 1'b1;
    @(posedge clk); #1;
    rearm = 1'b0;
    check(ready == 1'b1, "R7 rearm when idle", ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(intv == 1'b0 && done == 1'b0, "R8 reset state", {intv, done}, 0);
    srst = 1'b0;
    @(posedge clk); #1;
    check(ready == 1'b1, "R8 ready after reset", ready, 1);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #(VEC[i][0]);
      evt = 1'b1;
      t0 = $time;
      #1;
      check(intv == 1'b1, "R1 immediate start", intv, 1);
      @(posedge clk); #1;
      check(ready == 1'b0 && intv == 1'b1, "R2 disarm at first edge", {ready, intv}, 1);
      @(negedge intv);
      t1 = $time;
      check(t1 - t0 == VEC[i][1], "R3 close on second edge", t1 - t0, VEC[i][1]);
      check(t1 - t0 > CLK_PERIOD && t1 - t0 <= 2*CLK_PERIOD, "R4 length range", t1 - t0, VEC[i][1]);
      @(posedge clk); #1;
      check(done == 1'b1, "R5 done rises", done, 1);
      evt = 1'b0;
      @(posedge clk); #1;
      check(done == 1'b0, "R5 done one cycle", done, 0);
      check(ready == 1'b0, "R6 stays disarmed", ready, 0);
      do_rearm();
    end

    // R6: retrigger inside the interval, then events while disarmed
    @(posedge clk);
    #100 evt = 1'b1;
    t0 = $time;
    #300 evt = 1'b0;
    #100 evt = 1'b1;
    @(negedge intv);
    t1 = $time;
    check(t1 - t0 == 1900, "R6 retrigger ignored", t1 - t0, 1900);
    @(posedge clk); #1;
    evt = 1'b0;
    @(posedge clk); #1;
    evt = 1'b1;
    #1;
    check(intv == 1'b0, "R6 disarmed event ignored", intv, 0);
    repeat (2) @(posedge clk);
    #1;
    check(intv == 1'b0 && done == 1'b0, "R6 no interval later", {intv, done}, 0);
    evt = 1'b0;
    do_rearm();

    // R7: rearm while busy has no effect
    @(posedge clk);
    #300 evt = 1'b1;
    rearm = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rearm = 1'b0;
    check(done == 1'b1, "R7 done while rearm held", done, 1);
    evt = 1'b0;
    @(posedge clk); #1;
    check(ready == 1'b0, "R7 busy rearm ignored", ready, 0);
    do_rearm();

    // R8: events blocked during reset, reset aborts an open interval
    @(posedge clk); #1;
    srst = 1'b1;
    #200 evt = 1'b1;
    #1;
    check(intv == 1'b0, "R8 event blocked in reset", intv, 0);
    evt = 1'b0;
    @(posedge clk); #1;
    srst = 1'b0;
    @(posedge clk);
    #100 evt = 1'b1;
    #400 srst = 1'b1;
    evt = 1'b0;
    @(posedge clk); #1;
    check(intv == 1'b0 && done == 1'b0, "R8 reset aborts interval", {intv, done}, 0);
    srst = 1'b0;
    @(posedge clk); #1;
    check(ready == 1'b1 && done == 1'b0, "R8 ready after abort", {ready, done}, 2);

    // R9: falling-edge variant
    @(posedge clk);
    #200 evt_f = 1'b0;
    t0 = $time;
    #1;
    check(intv_f == 1'b1, "R9 falling edge starts", intv_f, 1);
    @(negedge intv_f);
    t1 = $time;
    check(t1 - t0 == 1800, "R9 falling edge length", t1 - t0, 1800);
    @(posedge clk); #1;
    check(done_f == 1'b1, "R9 done pulse", done_f, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule